// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit address of an instruction operand for a small 8-bit accumulator processor. The sequencer supplies the addressing mode, the operand bytes it has already fetched, the program counter and the two index registers, and strobes a request. One clock later the block presents the effective address, a flag saying whether a data memory access is needed, and a flag saying that the prefix byte steered indexed addressing to the second index register.

The meaning of the `pc` input depends on the mode. For immediate mode it is the address of the first byte of the instruction. If a prefix byte is present, that first byte is the prefix. For relative mode it is the address of the byte that follows the whole branch instruction. All address arithmetic wraps modulo 65536.

Top module: `eagen_top`

## Requirements
- R1: Mode code 0 (inherent) yields `ea` = 0x0000 and `mem_access` = 0.
- R2: Mode code 1 (immediate) yields `ea` = `pc` + 1, or `pc` + 2 when `alt_prefix` is 1, with `mem_access` = 1.
- R3: Mode code 2 (direct) yields `ea` = {0x00, `opnd_lo`}, so the address stays inside 0x0000..0x00FF, with `mem_access` = 1.
- R4: Mode code 3 (extended) yields `ea` = {`opnd_hi`, `opnd_lo`}, which can be any address, with `mem_access` = 1.
- R5: Mode code 4 (indexed) yields `ea` = index + `opnd_lo` taken as unsigned 0..255, with `mem_access` = 1. The index is `idx_a` when `alt_prefix` is 0 and `idx_b` when it is 1.
- R6: Mode code 5 (relative) yields `ea` = `pc` + `opnd_lo` sign-extended from bit 7, with `mem_access` = 0.
- R7: `alt_sel` is 1 exactly when the accepted request was indexed mode with `alt_prefix` = 1, and 0 otherwise.
- R8: Every 16-bit sum wraps modulo 65536 and raises no other indication.
- R9: Mode codes 6 and 7 yield `ea` = 0x0000, `mem_access` = 0 and `alt_sel` = 0.
- R10: A request with `req_valid` = 1 is reflected on `ea`, `mem_access` and `alt_sel` after the next rising edge. `res_valid` is 1 for that one cycle. While `req_valid` is 0, those three outputs hold and `res_valid` is 0.
- R11: A synchronous active-high `rst` clears `ea`, `mem_access`, `alt_sel` and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code (0..5 used) |
| alt_prefix | input | 1 | Prefix byte present; selects second index register |
| opnd_hi | input | 8 | First operand byte (high address byte in extended mode) |
| opnd_lo | input | 8 | Last operand byte (address low byte or offset) |
| pc | input | 16 | Program counter, meaning per mode as described above |
| idx_a | input | 16 | First index register |
| idx_b | input | 16 | Second index register |
| res_valid | output | 1 | Result presented this cycle |
| ea | output | 16 | Effective address |
| mem_access | output | 1 | Operand needs a data memory access |
| alt_sel | output | 1 | Second index register was used |

## Verification
The bench concentrates on the offset byte with bit 7 set. In indexed mode a design that sign-extends that byte would land up to 256 bytes below the intended address. In relative mode a design that zero-extends it would branch forward instead of backward. It also covers sums that cross 0xFFFF, where a wrong width would leak a carry or corrupt the low bits. It applies the prefix with immediate and indexed modes to catch a missing extra byte or an unswapped index register. Direct mode with 0xFF in both operand bytes exposes a high byte that is not forced to zero, and the idle cycles expose registers that update without a strobe.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [MODE_W-1:0] {
        AM_INHERENT = 3'd0,
        AM_IMMED    = 3'd1,
        AM_PAGE0    = 3'd2,
        AM_FULL     = 3'd3,
        AM_INDEXED  = 3'd4,
        AM_BRANCH   = 3'd5
    } amode_e;

    // Operands of the single address adder plus side flags.
    typedef struct packed {
        addr_t base;
        addr_t offset;
        logic  mem;
        logic  alt;
    } ea_term_t;

    // Registered result.
    typedef struct packed {
        addr_t ea;
        logic  mem;
        logic  alt;
    } ea_res_t;

    function automatic addr_t zext_byte(byte_t b);
        return {{(ADDR_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic addr_t sext_byte(byte_t b);
        return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/eagen_term_sel.sv
module eagen_term_sel
    import eagen_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              alt_prefix,
    input  byte_t             opnd_hi,
    input  byte_t             opnd_lo,
    input  addr_t             pc,
    input  addr_t             idx_a,
    input  addr_t             idx_b,
    output ea_term_t          term
);

    localparam addr_t ONE_BYTE = addr_t'(1);
    localparam addr_t TWO_BYTE = addr_t'(2);

    always_comb begin
        term = '0;
        case (mode)
            AM_INHERENT: begin
                term = '0;
            end
            AM_IMMED: begin
                term.base   = pc;
                term.offset = alt_prefix ? TWO_BYTE : ONE_BYTE;
                term.mem    = 1'b1;
            end
            AM_PAGE0: begin
                term.base   = '0;
                term.offset = zext_byte(opnd_lo);
                term.mem    = 1'b1;
            end
            AM_FULL: begin
                term.base   = {opnd_hi, opnd_lo};
                term.offset = '0;
                term.mem    = 1'b1;
            end
            AM_INDEXED: begin
                term.base   = alt_prefix ? idx_b : idx_a;
                term.offset = zext_byte(opnd_lo);
                term.mem    = 1'b1;
                term.alt    = alt_prefix;
            end
            AM_BRANCH: begin
                term.base   = pc;
                term.offset = sext_byte(opnd_lo);
                term.mem    = 1'b0;
            end
            default: begin
                term = '0;
            end
        endcase
    end

endmodule

// File: rtl/eagen_adder.sv
module eagen_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);

    logic [WIDTH:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        sum  = full[WIDTH-1:0];
    end

endmodule

// File: rtl/eagen_out_reg.sv
module eagen_out_reg
    import eagen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  ea_res_t d,
    output ea_res_t q,
    output logic    q_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  mode,
    input  logic        alt_prefix,
    input  logic [7:0]  opnd_hi,
    input  logic [7:0]  opnd_lo,
    input  logic [15:0] pc,
    input  logic [15:0] idx_a,
    input  logic [15:0] idx_b,
    output logic        res_valid,
    output logic [15:0] ea,
    output logic        mem_access,
    output logic        alt_sel
);

    ea_term_t term;
    addr_t    sum;
    ea_res_t  next_res;
    ea_res_t  cur_res;

    eagen_term_sel u_sel (
        .mode       (mode),
        .alt_prefix (alt_prefix),
        .opnd_hi    (opnd_hi),
        .opnd_lo    (opnd_lo),
        .pc         (pc),
        .idx_a      (idx_a),
        .idx_b      (idx_b),
        .term       (term)
    );

    eagen_adder #(.WIDTH(ADDR_W)) u_add (
        .a   (term.base),
        .b   (term.offset),
        .sum (sum)
    );

    always_comb begin
        next_res.ea  = sum;
        next_res.mem = term.mem;
        next_res.alt = term.alt;
    end

    eagen_out_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (req_valid),
        .d       (next_res),
        .q       (cur_res),
        .q_valid (res_valid)
    );

    assign ea         = cur_res.ea;
    assign mem_access = cur_res.mem;
    assign alt_sel    = cur_res.alt;

    p_inherent_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd0) |=> (ea == 16'h0000 && !mem_access));

    p_page0_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd2) |=> (ea[15:8] == 8'h00 && ea[7:0] == $past(opnd_lo) && mem_access));

    p_indexed_unsigned_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 3'd4) |=>
            (ea - ($past(alt_prefix) ? $past(idx_b) : $past(idx_a)) == {8'h00, $past(opnd_lo)}));

    p_alt_only_indexed_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode != 3'd4) |=> !alt_sel);

    p_unused_code_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode[2:1] == 2'b11) |=> (ea == 16'h0000 && !mem_access && !alt_sel));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(ea) && $stable(mem_access) && $stable(alt_sel)));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!res_valid && ea == 16'h0000 && !mem_access && !alt_sel));

endmodule

// File: tb/eagen_top_test.sv
module eagen_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        alt_prefix = 1'b0;
    logic [7:0]  opnd_hi = 8'h00;
    logic [7:0]  opnd_lo = 8'h00;
    logic [15:0] pc = 16'h0000;
    logic [15:0] idx_a = 16'h0000;
    logic [15:0] idx_b = 16'h0000;
    logic        res_valid;
    logic [15:0] ea;
    logic        mem_access;
    logic        alt_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eagen_top uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .mode       (mode),
        .alt_prefix (alt_prefix),
        .opnd_hi    (opnd_hi),
        .opnd_lo    (opnd_lo),
        .pc         (pc),
        .idx_a      (idx_a),
        .idx_b      (idx_b),
        .res_valid  (res_valid),
        .ea         (ea),
        .mem_access (mem_access),
        .alt_sel    (alt_sel)
    );

    // Expected {alt_sel, mem_access, ea} from the requirements.
    function automatic logic [17:0] expect_res(logic [2:0] m, logic p, logic [7:0] hi,
                                               logic [7:0] lo, logic [15:0] c,
                                               logic [15:0] a, logic [15:0] b);
        logic [15:0] e;
        logic        mm;
        logic        al;
        e = 16'h0000; mm = 1'b0; al = 1'b0;
        case (m)
            3'd1: begin e = c + (p ? 16'd2 : 16'd1); mm = 1'b1; end
            3'd2: begin e = {8'h00, lo}; mm = 1'b1; end
            3'd3: begin e = {hi, lo}; mm = 1'b1; end
            3'd4: begin e = (p ? b : a) + {8'h00, lo}; mm = 1'b1; al = p; end
            3'd5: begin e = c + {{8{lo[7]}}, lo}; end
            default: begin end
        endcase
        return {al, mm, e};
    endfunction

    task automatic check(string req, logic [17:0] got, logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(logic [2:0] m, logic p, logic [7:0] hi, logic [7:0] lo,
                         logic [15:0] c, logic [15:0] a, logic [15:0] b, string req);
        logic [17:0] exp;
        exp = expect_res(m, p, hi, lo, c, a, b);
        @(negedge clk);
        req_valid = 1'b1; mode = m; alt_prefix = p; opnd_hi = hi; opnd_lo = lo;
        pc = c; idx_a = a; idx_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {alt_sel, mem_access, ea}, exp);
        check({req, " res_valid"}, {17'd0, res_valid}, 18'd1);
    endtask

    initial begin
        logic [17:0] held;
        void'($urandom(32'hC0FFEE11));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {alt_sel, mem_access, ea}, 18'd0);
        check("R11 reset res_valid", {17'd0, res_valid}, 18'd0);
        rst = 1'b0;

        issue(3'd0, 1'b0, 8'hAB, 8'hCD, 16'h1234, 16'h1111, 16'h2222, "R1 inherent");
        issue(3'd1, 1'b0, 8'h00, 8'h00, 16'hC100, 16'h0, 16'h0, "R2 immediate");
        issue(3'd1, 1'b1, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0, "R2 R8 immediate prefix wrap");
        issue(3'd2, 1'b0, 8'hFF, 8'hFF, 16'h5555, 16'h0, 16'h0, "R3 direct top of page");
        issue(3'd3, 1'b0, 8'hFF, 8'hFF, 16'h0, 16'h0, 16'h0, "R4 extended max");
        issue(3'd3, 1'b0, 8'hC1, 8'h00, 16'h0, 16'h0, 16'h0, "R4 extended");
        issue(3'd4, 1'b0, 8'h00, 8'h80, 16'h0, 16'h1000, 16'h2000, "R5 indexed high offset");
        issue(3'd4, 1'b1, 8'h00, 8'h03, 16'h0, 16'h1000, 16'h2000, "R5 R7 indexed second reg");
        issue(3'd4, 1'b0, 8'h00, 8'hFF, 16'h0, 16'hFFFF, 16'h0, "R5 R8 indexed wrap");
        issue(3'd5, 1'b0, 8'h00, 8'h80, 16'h0010, 16'h0, 16'h0, "R6 relative backward");
        issue(3'd5, 1'b0, 8'h00, 8'h7F, 16'hFFF0, 16'h0, 16'h0, "R6 R8 relative forward wrap");
        issue(3'd5, 1'b1, 8'h00, 8'hFF, 16'h0000, 16'h0, 16'h0, "R6 R7 relative prefix ignored");
        issue(3'd6, 1'b1, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 16'hDEF0, "R9 unused 6");
        issue(3'd7, 1'b0, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 16'hDEF0, "R9 unused 7");

        // R10: no strobe, outputs hold
        issue(3'd4, 1'b1, 8'h00, 8'h44, 16'h0, 16'h0, 16'h8000, "R10 setup");
        held = {alt_sel, mem_access, ea};
        @(negedge clk);
        mode = 3'd3; opnd_hi = 8'h77; opnd_lo = 8'h66; alt_prefix = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold", {alt_sel, mem_access, ea}, held);
        check("R10 no res_valid", {17'd0, res_valid}, 18'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            issue(3'($urandom_range(0, 7)), 1'($urandom), 8'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), "R1 R2 R3 R4 R5 R6 R7 R9 random");
        end

        // R11: reset after activity
        issue(3'd3, 1'b0, 8'hBE, 8'hEF, 16'h0, 16'h0, 16'h0, "R4 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11 mid reset", {alt_sel, mem_access, ea}, 18'd0);
        check("R11 mid reset res_valid", {17'd0, res_valid}, 18'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule